// File: doc/BRIEF.md
# Interrupt Entry Context-Save Sequencer

This block sits next to a small 16-bit processor core and performs the hardware side of entering an interrupt. It accepts three kinds of entry request: maskable requests, non-maskable requests and software-interrupt commands. Each request carries a 6-bit vector index. Once it accepts a request, the block records the core's current program counter, code-segment value and status word. These go into one of two shadow banks: bank 1 serves maskable and software entries, and bank 2 serves non-maskable entries. The block then writes back an updated status word and finally hands the core the handler start address. That address is read from a 64-entry internal vector table.

The core presents its live PC, CSR and PSW on the inputs and applies the `psw_wr_o` and `pc_wr_o` strobes to its own registers. A request is a single-cycle pulse. A pulse that loses arbitration stays held inside the block until it is served. A pulse that arrives while an entry is in progress is discarded. The vector table resets to `VEC_BASE + 4*k` for entry k, and any entry can be overwritten through a write port.

Top module: `irq_entry_seq`

## Requirements
- R1: A maskable request is granted only while PSW bit 3 (interrupt enable) is 1. A maskable request seen while that bit is 0 stays held with no entry, and it is taken once the bit reads 1.
- R2: A maskable entry copies the core's PC, CSR and PSW into `elr1_o`, `ecsr1_o` and `epsw1_o`. Bank 2 is left unchanged.
- R3: On a maskable entry, the status word written on `psw_o` equals the pre-entry PSW with bit 3 cleared and bits [1:0] (exception level) set to 1.
- R4: A non-maskable request is taken whatever the value of PSW bit 3. It saves PC, CSR and PSW into `elr2_o`, `ecsr2_o` and `epsw2_o`, sets bits [1:0] to 2, leaves bit 3 as it was, and leaves bank 1 unchanged.
- R5: A software-interrupt command is taken whatever the value of PSW bit 3. It performs the same bank-1 save and status update as a maskable entry, and its own index selects the vector.
- R6: The writes follow this order, one clock edge each after the acceptance edge: ELR on edge 1, ECSR on edge 2, EPSW on edge 3. `psw_wr_o` is high in the cycle before edge 4, and `pc_wr_o` is high in the cycle before edge 5.
- R7: When requests are present together, non-maskable wins over software, and software wins over maskable. Each losing request is held and served in that order on later entries.
- R8: Vector entry k resets to 0x0100 + 4*k, and any entry can be rewritten through the vector write port. `pc_o` equals the entry selected by the granted index with bit 0 forced to 0.
- R9: `busy_o` is high for exactly the five cycles from the acceptance edge up to the edge that completes the PC load. Request pulses that arrive while `busy_o` is high are dropped.
- R10: The saved EPSW holds the status word as it was before entry, not the updated value.
- R11: After reset, `busy_o`, `psw_wr_o` and `pc_wr_o` are 0 and all shadow outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreq_i | input | 1 | Maskable request pulse |
| mreq_idx_i | input | 6 | Vector index of the maskable request |
| swi_i | input | 1 | Software-interrupt command pulse |
| swi_idx_i | input | 6 | Vector index of the software interrupt |
| nmi_i | input | 1 | Non-maskable request pulse |
| nmi_idx_i | input | 6 | Vector index of the non-maskable request |
| pc_i | input | 16 | Core program counter |
| csr_i | input | 8 | Core code-segment register |
| psw_i | input | 8 | Core status word (bit 3 enable, bits 1:0 level) |
| vec_we_i | input | 1 | Vector table write enable |
| vec_widx_i | input | 6 | Vector table write index |
| vec_wdata_i | input | 16 | Vector table write data |
| busy_o | output | 1 | Entry sequence in progress |
| psw_wr_o | output | 1 | Core PSW write strobe |
| psw_o | output | 8 | New status word |
| pc_wr_o | output | 1 | Core PC load strobe |
| pc_o | output | 16 | Handler start address |
| elr1_o | output | 16 | Bank 1 saved PC |
| ecsr1_o | output | 8 | Bank 1 saved CSR |
| epsw1_o | output | 8 | Bank 1 saved PSW |
| elr2_o | output | 16 | Bank 2 saved PC |
| ecsr2_o | output | 8 | Bank 2 saved CSR |
| epsw2_o | output | 8 | Bank 2 saved PSW |

## Verification
The hardest case to reach is a chain of held requests, where each entry's status-word update decides what the next entry may take. In that chain, a non-maskable entry keeps the enable bit, the software entry served after it clears the bit, and the maskable request behind both must then wait. The stimulus pulses all three classes in one cycle with the enable bit set, so that the scoreboard sees two back-to-back entries whose second save captures the first one's results. It then confirms that nothing further happens until the core model reloads the enable bit. A separate pulse sent during a busy window checks that late requests are dropped rather than held.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int NCLS    = 3;
  localparam int CLS_MI  = 0;
  localparam int CLS_SWI = 1;
  localparam int CLS_NMI = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE_PC,
    ST_SAVE_CSR,
    ST_SAVE_PSW,
    ST_FLAGS,
    ST_LOAD
  } seq_st_e;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            idle_i,
  input  logic                            mie_i,
  input  logic [NCLS-1:0]                 req_i,
  input  logic [NCLS-1:0][IDX_W-1:0]      idx_i,
  output logic [NCLS-1:0]                 gnt_o,
  output logic [IDX_W-1:0]                gnt_idx_o
);
  logic [NCLS-1:0]            pend_q;
  logic [NCLS-1:0]            live;
  logic [NCLS-1:0]            elig;
  logic [NCLS-1:0][IDX_W-1:0] pidx_q;
  logic [NCLS-1:0][IDX_W-1:0] idx_eff;

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    // pulses only count while idle; held ones persist through busy
    assign live[k]    = pend_q[k] | (req_i[k] & idle_i);
    assign idx_eff[k] = pend_q[k] ? pidx_q[k] : idx_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[k] <= 1'b0;
        pidx_q[k] <= '0;
      end else begin
        pend_q[k] <= live[k] & ~gnt_o[k];
        if (live[k] && !pend_q[k]) pidx_q[k] <= idx_i[k];
      end
    end
  end

  always_comb begin
    elig         = live;
    elig[CLS_MI] = live[CLS_MI] & mie_i;
  end

  always_comb begin
    gnt_o = '0;
    if (idle_i) begin
      for (int k = NCLS - 1; k >= 0; k--) begin
        if (elig[k] && gnt_o == '0) gnt_o[k] = 1'b1;
      end
    end
  end

  always_comb begin
    gnt_idx_o = '0;
    for (int k = 0; k < NCLS; k++) begin
      if (gnt_o[k]) gnt_idx_o = gnt_idx_o | idx_eff[k];
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)) else $error("grant not onehot"); // R7
  AST_MI_NEEDS_MIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[CLS_MI] |-> mie_i) else $error("masked grant"); // R1
  AST_NO_GNT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |-> gnt_o == '0) else $error("grant while busy"); // R9
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int PC_W     = 16,
  parameter int VEC_N    = 64,
  parameter int BASE     = 'h100,
  parameter int STRIDE   = 4,
  localparam int IDX_W   = $clog2(VEC_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [PC_W-1:0]  wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [PC_W-1:0]  raddr_o
);
  logic [PC_W-1:0] tbl_q [VEC_N];

  for (genvar k = 0; k < VEC_N; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 tbl_q[k] <= PC_W'(BASE + k * STRIDE);
      else if (we_i && widx_i == IDX_W'(k))        tbl_q[k] <= wdata_i;
    end
  end

  // handler addresses are word aligned
  assign raddr_o = tbl_q[ridx_i] & ~PC_W'(1);

  AST_VEC_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raddr_o[0]) else $error("odd vector"); // R8
endmodule

// File: rtl/irq_ctx_bank.sv
module irq_ctx_bank #(
  parameter int PC_W  = 16,
  parameter int CSR_W = 8,
  parameter int PSW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_pc_i,
  input  logic             we_csr_i,
  input  logic             we_psw_i,
  input  logic [PC_W-1:0]  pc_d_i,
  input  logic [CSR_W-1:0] csr_d_i,
  input  logic [PSW_W-1:0] psw_d_i,
  output logic [PC_W-1:0]  elr_o,
  output logic [CSR_W-1:0] ecsr_o,
  output logic [PSW_W-1:0] epsw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elr_o  <= '0;
      ecsr_o <= '0;
      epsw_o <= '0;
    end else begin
      if (we_pc_i)  elr_o  <= pc_d_i;
      if (we_csr_i) ecsr_o <= csr_d_i;
      if (we_psw_i) epsw_o <= psw_d_i;
    end
  end

  AST_CSR_AFTER_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_csr_i |-> $past(we_pc_i)) else $error("csr save out of order"); // R6
  AST_PSW_AFTER_CSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_psw_i |-> $past(we_csr_i)) else $error("psw save out of order"); // R6
  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_pc_i, we_csr_i, we_psw_i})) else $error("overlapping saves"); // R6
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int CSR_W      = 8,
  parameter int PSW_W      = 8,
  parameter int VEC_N      = 64,
  parameter int VEC_BASE   = 'h100,
  parameter int VEC_STRIDE = 4,
  parameter int MIE_BIT    = 3,
  parameter int ELV_LSB    = 0,
  parameter int ELV_W      = 2,
  localparam int IDX_W     = $clog2(VEC_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mreq_i,
  input  logic [IDX_W-1:0] mreq_idx_i,
  input  logic             swi_i,
  input  logic [IDX_W-1:0] swi_idx_i,
  input  logic             nmi_i,
  input  logic [IDX_W-1:0] nmi_idx_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [CSR_W-1:0] csr_i,
  input  logic [PSW_W-1:0] psw_i,
  input  logic             vec_we_i,
  input  logic [IDX_W-1:0] vec_widx_i,
  input  logic [PC_W-1:0]  vec_wdata_i,
  output logic             busy_o,
  output logic             psw_wr_o,
  output logic [PSW_W-1:0] psw_o,
  output logic             pc_wr_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  elr1_o,
  output logic [CSR_W-1:0] ecsr1_o,
  output logic [PSW_W-1:0] epsw1_o,
  output logic [PC_W-1:0]  elr2_o,
  output logic [CSR_W-1:0] ecsr2_o,
  output logic [PSW_W-1:0] epsw2_o
);
  localparam int NBANK = 2;

  seq_st_e                    st_q, st_d;
  logic                       idle;
  logic [NCLS-1:0]            req;
  logic [NCLS-1:0][IDX_W-1:0] req_idx;
  logic [NCLS-1:0]            gnt;
  logic [IDX_W-1:0]           gnt_idx;
  logic                       is_nmi_q;
  logic [IDX_W-1:0]           idx_q;
  logic [PC_W-1:0]            snap_pc_q;
  logic [CSR_W-1:0]           snap_csr_q;
  logic [PSW_W-1:0]           snap_psw_q;
  logic [PC_W-1:0]            vec_addr;
  logic [PC_W-1:0]            elr_w  [NBANK];
  logic [CSR_W-1:0]           ecsr_w [NBANK];
  logic [PSW_W-1:0]           epsw_w [NBANK];

  assign idle = (st_q == ST_IDLE);

  always_comb begin
    req              = '0;
    req[CLS_MI]      = mreq_i;
    req[CLS_SWI]     = swi_i;
    req[CLS_NMI]     = nmi_i;
    req_idx          = '0;
    req_idx[CLS_MI]  = mreq_idx_i;
    req_idx[CLS_SWI] = swi_idx_i;
    req_idx[CLS_NMI] = nmi_idx_i;
  end

  irq_arbiter #(.IDX_W(IDX_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idle_i    (idle),
    .mie_i     (psw_i[MIE_BIT]),
    .req_i     (req),
    .idx_i     (req_idx),
    .gnt_o     (gnt),
    .gnt_idx_o (gnt_idx)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (gnt != '0) st_d = ST_SAVE_PC;
      ST_SAVE_PC:  st_d = ST_SAVE_CSR;
      ST_SAVE_CSR: st_d = ST_SAVE_PSW;
      ST_SAVE_PSW: st_d = ST_FLAGS;
      ST_FLAGS:    st_d = ST_LOAD;
      ST_LOAD:     st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      is_nmi_q   <= 1'b0;
      idx_q      <= '0;
      snap_pc_q  <= '0;
      snap_csr_q <= '0;
      snap_psw_q <= '0;
    end else begin
      st_q <= st_d;
      if (idle && gnt != '0) begin
        // snapshot keeps the pre-entry state for the staged saves
        is_nmi_q   <= gnt[CLS_NMI];
        idx_q      <= gnt_idx;
        snap_pc_q  <= pc_i;
        snap_csr_q <= csr_i;
        snap_psw_q <= psw_i;
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = ((b == 1) == is_nmi_q);
    irq_ctx_bank #(.PC_W(PC_W), .CSR_W(CSR_W), .PSW_W(PSW_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_pc_i  (sel && st_q == ST_SAVE_PC),
      .we_csr_i (sel && st_q == ST_SAVE_CSR),
      .we_psw_i (sel && st_q == ST_SAVE_PSW),
      .pc_d_i   (snap_pc_q),
      .csr_d_i  (snap_csr_q),
      .psw_d_i  (snap_psw_q),
      .elr_o    (elr_w[b]),
      .ecsr_o   (ecsr_w[b]),
      .epsw_o   (epsw_w[b])
    );
  end

  irq_vec_table #(
    .PC_W   (PC_W),
    .VEC_N  (VEC_N),
    .BASE   (VEC_BASE),
    .STRIDE (VEC_STRIDE)
  ) u_vec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (vec_we_i),
    .widx_i  (vec_widx_i),
    .wdata_i (vec_wdata_i),
    .ridx_i  (idx_q),
    .raddr_o (vec_addr)
  );

  always_comb begin
    psw_o = snap_psw_q;
    if (is_nmi_q) begin
      psw_o[ELV_LSB +: ELV_W] = ELV_W'(2);
    end else begin
      psw_o[MIE_BIT]          = 1'b0;
      psw_o[ELV_LSB +: ELV_W] = ELV_W'(1);
    end
  end

  assign busy_o   = !idle;
  assign psw_wr_o = (st_q == ST_FLAGS);
  assign pc_wr_o  = (st_q == ST_LOAD);
  assign pc_o     = vec_addr;
  assign elr1_o   = elr_w[0];
  assign ecsr1_o  = ecsr_w[0];
  assign epsw1_o  = epsw_w[0];
  assign elr2_o   = elr_w[1];
  assign ecsr2_o  = ecsr_w[1];
  assign epsw2_o  = epsw_w[1];

  AST_LOAD_AFTER_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_o |-> $past(psw_wr_o)) else $error("pc load out of order"); // R6
  AST_NO_WR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !pc_wr_o && !psw_wr_o) else $error("strobe while idle"); // R9
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_o |=> !busy_o) else $error("busy overran load"); // R9
  AST_MASKED_CLEARS_MIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_wr_o && psw_o[ELV_LSB +: ELV_W] == ELV_W'(1) |-> !psw_o[MIE_BIT])
    else $error("enable left set"); // R3
  AST_NMI_KEEPS_MIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_wr_o && psw_o[ELV_LSB +: ELV_W] == ELV_W'(2) |-> psw_o[MIE_BIT] == psw_i[MIE_BIT])
    else $error("nmi touched enable"); // R4
  AST_PC_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_o |-> !pc_o[0]) else $error("odd handler address"); // R8
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        mreq = 0, swi = 0, nmi = 0;
  logic [5:0]  mreq_idx = 0, swi_idx = 0, nmi_idx = 0;
  logic        vec_we = 0;
  logic [5:0]  vec_widx = 0;
  logic [15:0] vec_wdata = 0;
  logic        busy, psw_wr, pc_wr;
  logic [7:0]  psw_new;
  logic [15:0] pc_new;
  logic [15:0] elr1, elr2;
  logic [7:0]  ecsr1, epsw1, ecsr2, epsw2;

  // core model
  logic        ld = 0;
  logic [15:0] ld_pc = 0;
  logic [7:0]  ld_csr = 0, ld_psw = 0;
  logic [15:0] core_pc;
  logic [7:0]  core_csr, core_psw;

  always @(posedge clk) begin
    if (!rst_n) begin
      core_pc <= 0; core_csr <= 0; core_psw <= 0;
    end else if (ld) begin
      core_pc <= ld_pc; core_csr <= ld_csr; core_psw <= ld_psw;
    end else begin
      if (psw_wr) core_psw <= psw_new;
      if (pc_wr)  core_pc  <= pc_new;
    end
  end

  irq_entry_seq u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .mreq_i(mreq), .mreq_idx_i(mreq_idx),
    .swi_i(swi), .swi_idx_i(swi_idx),
    .nmi_i(nmi), .nmi_idx_i(nmi_idx),
    .pc_i(core_pc), .csr_i(core_csr), .psw_i(core_psw),
    .vec_we_i(vec_we), .vec_widx_i(vec_widx), .vec_wdata_i(vec_wdata),
    .busy_o(busy), .psw_wr_o(psw_wr), .psw_o(psw_new),
    .pc_wr_o(pc_wr), .pc_o(pc_new),
    .elr1_o(elr1), .ecsr1_o(ecsr1), .epsw1_o(epsw1),
    .elr2_o(elr2), .ecsr2_o(ecsr2), .epsw2_o(epsw2)
  );

  typedef struct {
    string       tag;
    logic [15:0] pc;
    logic [7:0]  psw;
    logic [15:0] elr1; logic [7:0] ecsr1; logic [7:0] epsw1;
    logic [15:0] elr2; logic [7:0] ecsr2; logic [7:0] epsw2;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0, n_fail = 0, n_seen = 0, n_pushed = 0;
  logic [15:0] exp_vec [64];
  logic [15:0] m_pc; logic [7:0] m_csr, m_psw;
  logic [15:0] m_elr1, m_elr2; logic [7:0] m_ecsr1, m_epsw1, m_ecsr2, m_epsw2;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // driver side: predict one entry and queue it
  task automatic expect_entry(string tag, int cls, int idx);
    exp_t e;
    logic [7:0] np;
    np = m_psw;
    if (cls == 2) begin
      np[1:0] = 2'd2;
      m_elr2 = m_pc; m_ecsr2 = m_csr; m_epsw2 = m_psw;
    end else begin
      np[3] = 1'b0; np[1:0] = 2'd1;
      m_elr1 = m_pc; m_ecsr1 = m_csr; m_epsw1 = m_psw;
    end
    e.tag = tag; e.psw = np; e.pc = exp_vec[idx] & 16'hFFFE;
    e.elr1 = m_elr1; e.ecsr1 = m_ecsr1; e.epsw1 = m_epsw1;
    e.elr2 = m_elr2; e.ecsr2 = m_ecsr2; e.epsw2 = m_epsw2;
    m_psw = np; m_pc = e.pc;
    q.push_back(e);
    n_pushed++;
  endtask

  // monitor: at the load cycle the PSW write has already landed in the core
  always @(negedge clk) begin
    if (rst_n && pc_wr) begin
      n_seen++;
      if (q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R9 unexpected entry act=%h exp=none", pc_new);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " pc"},    pc_new,   e.pc);
        chk({e.tag, " psw"},   core_psw, e.psw);
        chk({e.tag, " elr1"},  elr1,     e.elr1);
        chk({e.tag, " ecsr1"}, ecsr1,    e.ecsr1);
        chk({e.tag, " epsw1"}, epsw1,    e.epsw1);
        chk({e.tag, " elr2"},  elr2,     e.elr2);
        chk({e.tag, " ecsr2"}, ecsr2,    e.ecsr2);
        chk({e.tag, " epsw2"}, epsw2,    e.epsw2);
      end
    end
  end

  task automatic load_core(logic [15:0] p, logic [7:0] c, logic [7:0] s);
    @(negedge clk); ld = 1; ld_pc = p; ld_csr = c; ld_psw = s;
    @(negedge clk); ld = 0;
    m_pc = p; m_csr = c; m_psw = s;
  endtask

  // mask bit 0 maskable, 1 software, 2 non-maskable
  task automatic pulse(logic [2:0] m, int mi, int si, int ni);
    @(negedge clk);
    mreq = m[0]; swi = m[1]; nmi = m[2];
    mreq_idx = 6'(mi); swi_idx = 6'(si); nmi_idx = 6'(ni);
    @(negedge clk);
    mreq = 0; swi = 0; nmi = 0;
  endtask

  task automatic idle_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) exp_vec[k] = 16'(16'h0100 + 4 * k);
    m_elr1 = 0; m_ecsr1 = 0; m_epsw1 = 0; m_elr2 = 0; m_ecsr2 = 0; m_epsw2 = 0;
    m_pc = 0; m_csr = 0; m_psw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 strobes", {psw_wr, pc_wr}, 0);
    chk("R11 bank1", {elr1, ecsr1, epsw1}, 0);
    chk("R11 bank2", {elr2, ecsr2, epsw2}, 0);

    // R2 R3 R6 R10 maskable entry with per-cycle staging
    load_core(16'h1234, 8'h5A, 8'hC8);
    expect_entry("R2/R3 maskable", 0, 5);
    pulse(3'b001, 5, 0, 0);
    chk("R9 busy rises", busy, 1);
    chk("R6 elr not yet", elr1, 0);
    @(negedge clk);
    chk("R6 elr edge1", elr1, 16'h1234);
    chk("R6 ecsr not yet", ecsr1, 0);
    @(negedge clk);
    chk("R6 ecsr edge2", ecsr1, 8'h5A);
    chk("R6 epsw not yet", epsw1, 0);
    @(negedge clk);
    chk("R10 epsw pre-entry", epsw1, 8'hC8);
    chk("R6 psw_wr", {psw_wr, pc_wr}, 2'b10);
    chk("R3 psw value", psw_new, 8'hC1);
    @(negedge clk);
    chk("R6 pc_wr", {psw_wr, pc_wr}, 2'b01);
    chk("R9 busy during load", busy, 1);
    @(negedge clk);
    chk("R9 busy falls", busy, 0);

    // R4 non-maskable with enable set, then with enable clear
    load_core(16'h4000, 8'h11, 8'hA8);
    expect_entry("R4 nmi mie1", 2, 3);
    pulse(3'b100, 0, 0, 3);
    idle_wait(8);
    load_core(16'h4100, 8'h22, 8'h30);
    expect_entry("R4 nmi mie0", 2, 10);
    pulse(3'b100, 0, 0, 10);
    idle_wait(8);

    // R5 software entry ignores the enable bit
    load_core(16'h5550, 8'h33, 8'h40);
    expect_entry("R5 swi", 1, 9);
    pulse(3'b010, 0, 9, 0);
    idle_wait(8);

    // R1 maskable held while enable is 0
    load_core(16'h6000, 8'h44, 8'h02);
    pulse(3'b001, 4, 0, 0);
    idle_wait(10);
    chk("R1 held no busy", busy, 0);
    chk("R1 held no entry", n_seen, n_pushed);
    load_core(16'h6000, 8'h44, 8'h0A);
    expect_entry("R1 released", 0, 4);
    idle_wait(8);

    // R7 all three at once: nmi, then swi, maskable waits on enable
    load_core(16'h7000, 8'h55, 8'h08);
    expect_entry("R7 first nmi", 2, 1);
    expect_entry("R7 then swi", 1, 2);
    pulse(3'b111, 6, 2, 1);
    idle_wait(16);
    chk("R7 mi waits", n_seen, n_pushed);
    chk("R7 idle", busy, 0);
    load_core(16'h7100, 8'h66, 8'h88);
    expect_entry("R7 last mi", 0, 6);
    idle_wait(8);

    // R9 pulse during busy is dropped
    load_core(16'h8000, 8'h77, 8'h00);
    expect_entry("R9 nmi", 2, 20);
    pulse(3'b100, 0, 0, 20);
    pulse(3'b010, 0, 21, 0);
    idle_wait(12);
    chk("R9 dropped", n_seen, n_pushed);
    chk("R9 idle after", busy, 0);

    // R8 rewritten odd entry and top default entry
    @(negedge clk); vec_we = 1; vec_widx = 7; vec_wdata = 16'h2345;
    @(negedge clk); vec_we = 0;
    exp_vec[7] = 16'h2345;
    load_core(16'h9000, 8'h01, 8'h08);
    expect_entry("R8 odd entry", 1, 7);
    pulse(3'b010, 0, 7, 0);
    idle_wait(8);
    expect_entry("R8 entry63", 1, 63);
    pulse(3'b010, 0, 63, 0);
    idle_wait(8);

    chk("queue drained", q.size(), 0);
    chk("entry count", n_seen, n_pushed);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule